// File: doc/BRIEF.md
# 8-bit Arithmetic Flag and Decimal Adjust Unit

This block is the arithmetic slice of a small 8-bit datapath. It adds, adds with carry, subtracts, subtracts with borrow, compares and decimal-adjusts. It produces its result byte combinationally from the two operand bytes, the operation code and the stored flags. On each clock edge it writes the new carry, zero, sign, overflow, decimal-adjust and half-carry values into an internal flag register, which it drives out as a flag byte.

The stored decimal-adjust flag records whether the last arithmetic operation was add-type or subtract-type. The decimal-adjust operation uses that flag, the stored half-carry and the stored carry to correct a binary sum or difference of two packed-BCD bytes into a valid packed-BCD byte. The byte to be corrected is supplied on operand A.

Top module: `alu_flag_unit`

## Requirements
- R1: ADD (op 1) gives result_o = (a_i + b_i) mod 256 and sets carry when the sum exceeds 255. For example, 225 + 64 gives 0x21 with carry 1.
- R2: ADC (op 2) adds the stored carry as well: result_o = (a_i + b_i + C) mod 256, and carry is set when that sum exceeds 255.
- R3: SUB (op 3) gives result_o = (a_i - b_i) mod 256. SBC (op 4) also subtracts the stored carry. For both, carry is set when a borrow occurs, that is, when the true difference is negative.
- R4: After ADD, ADC, SUB, SBC, CMP or DA, the zero flag is 1 exactly when the 8-bit result is 0x00.
- R5: After ADD, ADC, SUB, SBC, CMP or DA, the sign flag equals bit 7 of the result.
- R6: After ADD, ADC, SUB, SBC or CMP, the overflow flag is set exactly when the signed result lies outside -128..127. For example, 120 + 105 gives 0xE1 with overflow 1. DA leaves the overflow flag unchanged.
- R7: On addition, half-carry records a carry out of bit 3 (low nibbles plus carry-in exceed 15). On subtraction, half-carry records a borrow into bit 3 (the low nibble of a_i is less than the low nibble of b_i plus the borrow-in).
- R8: ADD and ADC clear the decimal-adjust flag. SUB, SBC and CMP set it.
- R9: CMP (op 5) updates every flag exactly as SUB would. result_o stays equal to a_i, so no difference is delivered.
- R10: DA (op 6) with the stored decimal-adjust flag at 0 adds 0x06 when H=1 or a_i[3:0] > 9. It adds 0x60 and sets carry when C=1 or a_i > 0x99; otherwise it clears carry.
- R11: DA with the stored decimal-adjust flag at 1 subtracts 0x06 when H=1 and subtracts 0x60 when C=1. Carry is left unchanged.
- R12: DA leaves the decimal-adjust and half-carry flags unchanged. NOP (op 0) and op 7 leave all flags unchanged and give result_o = a_i.
- R13: flags_o holds C at bit 7, Z at bit 6, S at bit 5, V at bit 4, D at bit 3 and H at bit 2, with bits 1:0 always 0. All flags reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code |
| a_i | input | 8 | Operand A (also the byte to decimal-adjust) |
| b_i | input | 8 | Operand B |
| result_o | output | 8 | Combinational result |
| flags_o | output | 8 | Stored flag byte |

## Verification
The in-RTL assertions check the following on every cycle: the decimal-adjust flag tracks the type of the last arithmetic operation; zero and sign follow the previous result; idle codes keep the flags stable; and DA after a subtraction preserves carry. Exact arithmetic values cannot be shown by properties alone. These include carry and borrow across ADC/SBC chains, overflow boundaries, half-carry and both BCD correction paths. The bench's behavioural model checks them over directed BCD sequences and random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_ADC = 3'd2,
    OP_SUB = 3'd3,
    OP_SBC = 3'd4,
    OP_CMP = 3'd5,
    OP_DA  = 3'd6,
    OP_RSV = 3'd7
  } op_e;

  localparam int FC = 7;
  localparam int FZ = 6;
  localparam int FS = 5;
  localparam int FV = 4;
  localparam int FD = 3;
  localparam int FH = 2;
endpackage

// File: rtl/arith_core.sv
module arith_core
  import alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          h_o,
  output logic          v_o
);
  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic          c_raw;
  logic          h_raw;
  logic [NW-1:0] lo_unused;

  // subtraction as a + ~b + ~borrow
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = sub_i ? ~cin_i : cin_i;
  assign {c_raw, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
  assign {h_raw, lo_unused} = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
  assign c_o = sub_i ? ~c_raw : c_raw;
  assign h_o = sub_i ? ~h_raw : h_raw;
  assign v_o = (a_i[DW-1] == b_eff[DW-1]) && (sum_o[DW-1] != a_i[DW-1]);
endmodule

// File: rtl/bcd_adjust.sv
module bcd_adjust
  import alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic          d_i,
  input  logic          h_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  logic          lo_fix;
  logic          hi_fix;
  logic [DW-1:0] corr;

  always_comb begin
    if (!d_i) begin
      lo_fix = h_i || (a_i[NW-1:0] > 4'd9);
      hi_fix = c_i || (a_i > 8'h99);
    end else begin
      lo_fix = h_i;
      hi_fix = c_i;
    end
    corr  = {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
    res_o = d_i ? (a_i - corr) : (a_i + corr);
    c_o   = d_i ? c_i : hi_fix;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] result_o,
  output logic [DW-1:0] flags_o
);
  op_e           op;
  logic [DW-1:0] flags_q, flags_d;
  logic          is_add, is_sub, use_cin;
  logic [DW-1:0] ar_sum, da_res;
  logic          ar_c, ar_h, ar_v, da_c;

  assign op      = op_e'(op_i);
  assign is_add  = (op == OP_ADD) || (op == OP_ADC);
  assign is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign use_cin = (op == OP_ADC) || (op == OP_SBC);

  arith_core u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (use_cin & flags_q[FC]),
    .sub_i (is_sub),
    .sum_o (ar_sum),
    .c_o   (ar_c),
    .h_o   (ar_h),
    .v_o   (ar_v)
  );

  bcd_adjust u_bcd (
    .a_i   (a_i),
    .d_i   (flags_q[FD]),
    .h_i   (flags_q[FH]),
    .c_i   (flags_q[FC]),
    .res_o (da_res),
    .c_o   (da_c)
  );

  logic [DW-1:0] flag_src;

  always_comb begin
    result_o = a_i;
    flag_src = a_i;
    flags_d  = flags_q;
    if (is_add || is_sub) begin
      flag_src = ar_sum;
      if (op != OP_CMP) result_o = ar_sum;
      flags_d[FC] = ar_c;
      flags_d[FV] = ar_v;
      flags_d[FH] = ar_h;
      flags_d[FD] = is_sub;
    end else if (op == OP_DA) begin
      result_o    = da_res;
      flag_src    = da_res;
      flags_d[FC] = da_c;
    end
    if (is_add || is_sub || op == OP_DA) begin
      flags_d[FZ] = (flag_src == '0);
      flags_d[FS] = flag_src[DW-1];
    end
    flags_d[1:0] = 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R8
  d_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_add || is_sub) |=> (flags_o[FD] == $past(is_sub)));
  // R4
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_add || (is_sub && op != OP_CMP) || op == OP_DA) |=> (flags_o[FZ] == ($past(result_o) == '0)));
  // R5
  sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_add || (is_sub && op != OP_CMP) || op == OP_DA) |=> (flags_o[FS] == $past(result_o[DW-1])));
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_NOP || op == OP_RSV) |=> $stable(flags_o));
  // R11
  da_sub_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_DA && flags_o[FD]) |=> $stable(flags_o[FC]));
  // R9
  cmp_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CMP) |-> (result_o == a_i));
endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic [2:0] op_i = 0;
  logic [7:0] a_i = 0, b_i = 0;
  logic [7:0] result_o, flags_o;

  int n_cmp = 0, n_bad = 0;
  int mc = 0, mz = 0, ms = 0, mv = 0, md = 0, mh = 0;
  logic [7:0] exp_res;
  string pend_tag = "R13";
  bit done = 0;

  alu_flag_unit dut (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog R13 actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] mflags();
    return {mc[0], mz[0], ms[0], mv[0], md[0], mh[0], 2'b00};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // behavioural model: returns expected result, updates model flags
  task automatic model(int op, int a, int b);
    int s, sa, sb, sv, cin, r, lo, hi;
    cin = (op == 2 || op == 4) ? mc : 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    r = a;
    if (op == 1 || op == 2) begin
      s = a + b + cin; r = s % 256;
      mc = (s > 255); mh = ((a % 16) + (b % 16) + cin > 15);
      sv = sa + sb + cin; mv = (sv > 127 || sv < -128); md = 0;
    end else if (op == 3 || op == 4 || op == 5) begin
      s = a - b - cin; r = (s + 256) % 256;
      mc = (s < 0); mh = ((a % 16) - (b % 16) - cin < 0);
      sv = sa - sb - cin; mv = (sv > 127 || sv < -128); md = 1;
    end else if (op == 6) begin
      if (md == 0) begin
        lo = (mh || (a % 16) > 9); hi = (mc || a > 153);
        r = (a + (lo ? 6 : 0) + (hi ? 96 : 0)) % 256; mc = hi;
      end else begin
        r = (a - (mh ? 6 : 0) - (mc ? 96 : 0) + 256) % 256;
      end
    end
    if (op >= 1 && op <= 6) begin
      mz = (r == 0); ms = (r > 127);
    end
    exp_res = (op == 5) ? a[7:0] : r[7:0];
  endtask

  task automatic do_op(string tag, int op, int a, int b);
    @(negedge clk_i);
    chk({pend_tag, " flags"}, flags_o, mflags());
    op_i = op[2:0]; a_i = a[7:0]; b_i = b[7:0];
    model(op, a, b);
    #2;
    chk({tag, " result"}, result_o, exp_res);
    pend_tag = tag;
  endtask

  initial begin
    #5;
    chk("R13 reset", flags_o, 8'h00);
    #30 rst_ni = 1;
    do_op("R1", 1, 225, 64);
    do_op("R2", 2, 10, 20);
    do_op("R6", 1, 120, 105);
    do_op("R4", 1, 128, 128);
    do_op("R2", 2, 0, 0);
    do_op("R3", 3, 5, 9);
    do_op("R3", 4, 5, 4);
    do_op("R7", 3, 16, 1);
    do_op("R9", 5, 7, 7);
    do_op("R12", 0, 1, 2);
    do_op("R12", 7, 3, 4);
    do_op("R6", 3, 128, 1);
    // BCD add: 38 + 45 = 83
    do_op("R10", 1, 8'h38, 8'h45);
    do_op("R10", 6, 8'h7D, 0);
    // 99 + 01
    do_op("R10", 1, 8'h99, 8'h01);
    do_op("R10", 6, 8'h9A, 0);
    // 98 + 09 with half carry
    do_op("R7", 1, 8'h98, 8'h09);
    do_op("R10", 6, 8'hA1, 0);
    // BCD sub: 42 - 17 = 25
    do_op("R11", 3, 8'h42, 8'h17);
    do_op("R11", 6, 8'h2B, 0);
    // 10 - 20 borrow
    do_op("R11", 3, 8'h10, 8'h20);
    do_op("R11", 6, 8'hF0, 0);
    do_op("R12", 6, 8'h00, 0);
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 7);
      do_op("R5", op, $urandom_range(0, 255), $urandom_range(0, 255));
    end
    @(negedge clk_i);
    chk({pend_tag, " flags"}, flags_o, mflags());
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule